// File: doc/BRIEF.md
# Interrupt Claim and Completion Controller

This block arbitrates a set of interrupt sources onto a set of targets (for example, processor harts). Each source has a pending latch, a programmable priority and an in-flight mark. Each target has an enable mask over the sources and a priority threshold. A target's interrupt line is raised when at least one source it has enabled is pending with a priority above its threshold.

A target takes work through its claim port. The claim returns the best eligible source and moves that source from pending to in-flight. The target later writes the same ID to the completion port to re-arm the source. Sources are handled independently of one another. A target may therefore hold several claimed sources at once and complete them in any order. A completion is never compared with the ID the target last claimed. Register-bus decoding and edge detection are outside the block; each source presents a simple request level.

Top module: `irq_claim_ctl`

## Requirements
- R1: After reset, all pending and in-flight marks, priorities, enable masks and thresholds are zero, `claim_id` reads 0 and every `irq` bit is low.
- R2: `claim_id` is the ID of the source that is pending, enabled in the mask of target `claim_tgt` and has a nonzero priority, with the largest priority and, among equal priorities, the lowest ID; it is 0 when no source qualifies (a priority of 0 never qualifies).
- R3: The value of `claim_id` does not depend on any target's threshold.
- R4: A claim (`claim_vld` high with a nonzero `claim_id`) clears that source's pending bit and sets its in-flight mark at the next clock edge; while in flight, the source does not become pending again even with its request held high.
- R5: `irq[t]` is high exactly when some pending source enabled for target t has a priority strictly greater than the threshold of target t.
- R6: A completion (`cmpl_vld` high) whose `cmpl_id` is nonzero and enabled in the mask of `cmpl_tgt` clears that source's in-flight mark, whichever source that target claimed last; completions of several in-flight sources may arrive in any order.
- R7: A completion whose ID is 0 or is not enabled for the writing target changes no state.
- R8: Source 0 is reserved: it never becomes pending and is never returned by a claim.
- R9: A nonzero source whose request is high and that is not in flight becomes pending at the next edge; a pending bit stays set until the source is claimed, even if the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Request level per source |
| prio_we | input | 1 | Write strobe for a source priority |
| prio_sel | input | ID_W | Source whose priority is written |
| prio_val | input | PRIO_W | New priority value |
| en_we | input | 1 | Write strobe for a target enable mask |
| en_tgt | input | TGT_W | Target whose mask is written |
| en_mask | input | NUM_SRC | New enable mask, bit s for source s |
| thr_we | input | 1 | Write strobe for a target threshold |
| thr_tgt | input | TGT_W | Target whose threshold is written |
| thr_val | input | PRIO_W | New threshold value |
| claim_vld | input | 1 | Claim performed this cycle by `claim_tgt` |
| claim_tgt | input | TGT_W | Target that claims or whose claim result is shown |
| claim_id | output | ID_W | Claim result for `claim_tgt`, valid in the same cycle |
| cmpl_vld | input | 1 | Completion write strobe |
| cmpl_tgt | input | TGT_W | Target that writes the completion |
| cmpl_id | input | ID_W | Source ID being completed |
| irq | output | NUM_TGT | Interrupt line per target |

## Verification
The assertions assume that `claim_tgt` and `cmpl_tgt` name existing targets and that the configuration writes name existing sources and targets. Under those inputs, pending and in-flight marks for a source never coexist. The bench's random phase draws target indices only from the valid range and draws IDs across the whole ID space, including 0. It issues completions for sources that are not in flight, not enabled for the writer, or just claimed, so the drop and same-cycle rules are reached while the inputs stay within those assumptions.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;

    // Widest priority and ID the selector datapath carries.
    localparam int MAX_PRIO_W = 8;
    localparam int MAX_ID_W   = 8;

    typedef struct packed {
        logic                  vld;
        logic [MAX_PRIO_W-1:0] prio;
        logic [MAX_ID_W-1:0]   id;
    } irq_cand_t;

    // A challenger wins only with a strictly larger priority, so an
    // ascending scan keeps the lowest ID on ties.
    function automatic logic cand_beats(irq_cand_t chal, irq_cand_t best);
        return chal.vld && (!best.vld || chal.prio > best.prio);
    endfunction

endpackage

// File: rtl/irq_ctl_sel.sv
`timescale 1ns/1ps
module irq_ctl_sel
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             elig,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr,
    output logic [ID_W-1:0]                best_id,
    output logic                           above_thr
);

    irq_cand_t best;

    always_comb begin
        irq_cand_t cand;
        best      = '0;
        above_thr = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            cand.vld  = elig[s] && (prio[s] != '0);
            cand.prio = MAX_PRIO_W'(prio[s]);
            cand.id   = MAX_ID_W'(s);
            if (cand_beats(cand, best))
                best = cand;
            if (cand.vld && (prio[s] > thr))
                above_thr = 1'b1;
        end
    end

    assign best_id = best.vld ? ID_W'(best.id) : '0;

endmodule

// File: rtl/irq_ctl_track.sv
`timescale 1ns/1ps
module irq_ctl_track #(
    parameter int NUM_SRC = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic               take_vld,
    input  logic [ID_W-1:0]    take_id,
    input  logic               give_vld,
    input  logic [ID_W-1:0]    give_id,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] infl_q
);

    logic [NUM_SRC-1:0] pend_n, infl_n;

    always_comb begin
        pend_n = pend_q;
        infl_n = infl_q;
        if (give_vld && (int'(give_id) < NUM_SRC))
            infl_n[give_id] = 1'b0;
        if (take_vld && (int'(take_id) < NUM_SRC)) begin
            pend_n[take_id] = 1'b0;
            infl_n[take_id] = 1'b1;
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s] && !infl_q[s] && !(take_vld && int'(take_id) == s))
                pend_n[s] = 1'b1;
        end
        pend_n[0] = 1'b0;
        infl_n[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            infl_q <= '0;
        end else begin
            pend_q <= pend_n;
            infl_q <= infl_n;
        end
    end

    // R4
    pend_infl_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & infl_q) == '0);

    // R8
    src0_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q[0] && !infl_q[0]);

    // R4
    take_moves_chk: assert property (@(posedge clk) disable iff (rst)
        take_vld && take_id != '0 |=> infl_q[$past(take_id)] && !pend_q[$past(take_id)]);

    // R6
    give_rearms_chk: assert property (@(posedge clk) disable iff (rst)
        give_vld && !(take_vld && take_id == give_id) |=> !infl_q[$past(give_id)]);

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !take_vld |=> ($past(pend_q) & ~pend_q) == '0);

endmodule

// File: rtl/irq_claim_ctl.sv
`timescale 1ns/1ps
module irq_claim_ctl #(
    parameter int NUM_SRC  = 8,
    parameter int NUM_TGT  = 2,
    parameter int PRIO_W   = 3,
    localparam int ID_W    = $clog2(NUM_SRC),
    localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               prio_we,
    input  logic [ID_W-1:0]    prio_sel,
    input  logic [PRIO_W-1:0]  prio_val,
    input  logic               en_we,
    input  logic [TGT_W-1:0]   en_tgt,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic               thr_we,
    input  logic [TGT_W-1:0]   thr_tgt,
    input  logic [PRIO_W-1:0]  thr_val,
    input  logic               claim_vld,
    input  logic [TGT_W-1:0]   claim_tgt,
    output logic [ID_W-1:0]    claim_id,
    input  logic               cmpl_vld,
    input  logic [TGT_W-1:0]   cmpl_tgt,
    input  logic [ID_W-1:0]    cmpl_id,
    output logic [NUM_TGT-1:0] irq
);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_TGT-1:0][NUM_SRC-1:0] en_q;
    logic [NUM_TGT-1:0][PRIO_W-1:0]  thr_q;
    logic [NUM_SRC-1:0]              pend, infl;
    logic [NUM_TGT-1:0][ID_W-1:0]    best_ids;
    logic                            take_vld, cmpl_ok;

    // Configuration state
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else begin
            if (prio_we && int'(prio_sel) < NUM_SRC)
                prio_q[prio_sel] <= prio_val;
            if (en_we && int'(en_tgt) < NUM_TGT)
                en_q[en_tgt] <= en_mask;
            if (thr_we && int'(thr_tgt) < NUM_TGT)
                thr_q[thr_tgt] <= thr_val;
        end
    end

    // One selector per target; the threshold only feeds the line.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        irq_ctl_sel #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
            .elig      (pend & en_q[t]),
            .prio      (prio_q),
            .thr       (thr_q[t]),
            .best_id   (best_ids[t]),
            .above_thr (irq[t])
        );
    end

    assign claim_id = (int'(claim_tgt) < NUM_TGT) ? best_ids[claim_tgt] : '0;
    assign take_vld = claim_vld && (claim_id != '0);

    // Completion checked only against the writer's enable mask.
    assign cmpl_ok = cmpl_vld && (cmpl_id != '0) && (int'(cmpl_id) < NUM_SRC)
                  && (int'(cmpl_tgt) < NUM_TGT) && en_q[cmpl_tgt][cmpl_id];

    irq_ctl_track #(.NUM_SRC(NUM_SRC)) u_track (
        .clk      (clk),
        .rst      (rst),
        .req      (src_req),
        .take_vld (take_vld),
        .take_id  (claim_id),
        .give_vld (cmpl_ok),
        .give_id  (cmpl_id),
        .pend_q   (pend),
        .infl_q   (infl)
    );

    // R2
    claim_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        claim_vld && claim_id != '0 |-> pend[claim_id] && en_q[claim_tgt][claim_id]
                                        && prio_q[claim_id] != '0);

    // R7
    bad_cmpl_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        cmpl_vld && !cmpl_ok && !take_vld |=> $stable(infl));

endmodule

// File: tb/tb_irq_claim_ctl.sv
`timescale 1ns/1ps
module tb_irq_claim_ctl;

    localparam int NS = 8;
    localparam int NT = 2;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] src_req;
    logic          prio_we;
    logic [2:0]    prio_sel;
    logic [PW-1:0] prio_val;
    logic          en_we;
    logic [0:0]    en_tgt;
    logic [NS-1:0] en_mask;
    logic          thr_we;
    logic [0:0]    thr_tgt;
    logic [PW-1:0] thr_val;
    logic          claim_vld;
    logic [0:0]    claim_tgt;
    logic [2:0]    claim_id;
    logic          cmpl_vld;
    logic [0:0]    cmpl_tgt;
    logic [2:0]    cmpl_id;
    logic [NT-1:0] irq;

    irq_claim_ctl #(.NUM_SRC(NS), .NUM_TGT(NT), .PRIO_W(PW)) dut (
        .clk(clk), .rst(rst), .src_req(src_req),
        .prio_we(prio_we), .prio_sel(prio_sel), .prio_val(prio_val),
        .en_we(en_we), .en_tgt(en_tgt), .en_mask(en_mask),
        .thr_we(thr_we), .thr_tgt(thr_tgt), .thr_val(thr_val),
        .claim_vld(claim_vld), .claim_tgt(claim_tgt), .claim_id(claim_id),
        .cmpl_vld(cmpl_vld), .cmpl_tgt(cmpl_tgt), .cmpl_id(cmpl_id),
        .irq(irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model state
    int m_prio[NS];
    bit m_pend[NS];
    bit m_infl[NS];
    bit m_en[NT][NS];
    int m_thr[NT];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_claim(int t);
        int best = 0;
        int bp = 0;
        for (int s = 1; s < NS; s++)
            if (m_pend[s] && m_en[t][s] && m_prio[s] > bp) begin
                best = s;
                bp = m_prio[s];
            end
        return best;
    endfunction

    function automatic bit exp_irq(int t);
        for (int s = 1; s < NS; s++)
            if (m_pend[s] && m_en[t][s] && m_prio[s] != 0 && m_prio[s] > m_thr[t])
                return 1'b1;
        return 1'b0;
    endfunction

    // Compare, advance the model across the coming edge, move to next negedge.
    task automatic tick();
        int tk;
        bit ok;
        bit old_infl[NS];
        #1;
        if (!rst) begin
            chk(claim_id == 3'(exp_claim(int'(claim_tgt))), "R2/R3 claim_id",
                int'(claim_id), exp_claim(int'(claim_tgt)));
            for (int t = 0; t < NT; t++)
                chk(irq[t] == exp_irq(t), "R5 irq", int'(irq[t]), int'(exp_irq(t)));
        end
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_prio[s] = 0; m_pend[s] = 0; m_infl[s] = 0;
                for (int t = 0; t < NT; t++) m_en[t][s] = 0;
            end
            for (int t = 0; t < NT; t++) m_thr[t] = 0;
        end else begin
            tk = claim_vld ? exp_claim(int'(claim_tgt)) : 0;
            ok = cmpl_vld && cmpl_id != 0 && m_en[cmpl_tgt][cmpl_id];
            for (int s = 0; s < NS; s++) old_infl[s] = m_infl[s];
            if (ok) m_infl[cmpl_id] = 0;
            if (tk != 0) begin
                m_pend[tk] = 0;
                m_infl[tk] = 1;
            end
            for (int s = 1; s < NS; s++)
                if (src_req[s] && !old_infl[s] && s != tk) m_pend[s] = 1;
            if (prio_we) m_prio[prio_sel] = int'(prio_val);
            if (en_we) for (int s = 0; s < NS; s++) m_en[en_tgt][s] = en_mask[s];
            if (thr_we) m_thr[thr_tgt] = int'(thr_val);
        end
        @(negedge clk);
    endtask

    task automatic look();
        #0.5;
    endtask

    task automatic set_prio(int s, int v);
        prio_we = 1; prio_sel = 3'(s); prio_val = PW'(v);
        tick();
        prio_we = 0;
    endtask

    task automatic set_en(int t, int m);
        en_we = 1; en_tgt = 1'(t); en_mask = NS'(m);
        tick();
        en_we = 0;
    endtask

    task automatic set_thr(int t, int v);
        thr_we = 1; thr_tgt = 1'(t); thr_val = PW'(v);
        tick();
        thr_we = 0;
    endtask

    task automatic complete(int t, int id);
        cmpl_vld = 1; cmpl_tgt = 1'(t); cmpl_id = 3'(id);
        tick();
        cmpl_vld = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; src_req = '0;
        prio_we = 0; prio_sel = '0; prio_val = '0;
        en_we = 0; en_tgt = '0; en_mask = '0;
        thr_we = 0; thr_tgt = '0; thr_val = '0;
        claim_vld = 0; claim_tgt = '0;
        cmpl_vld = 0; cmpl_tgt = '0; cmpl_id = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;

        look();
        chk(claim_id == 0, "R1 claim_id after reset", int'(claim_id), 0);
        chk(irq == 0, "R1 irq after reset", int'(irq), 0);
        tick();

        set_prio(0, 7); set_prio(1, 2); set_prio(2, 5);
        set_prio(3, 5); set_prio(4, 0); set_prio(5, 7);
        set_en(0, 'h3F); set_en(1, 'h06);
        set_thr(0, 7);
        src_req = 8'h1F;
        tick();
        src_req = '0;
        tick();

        claim_tgt = 0;
        look();
        chk(claim_id == 2, "R2 tie broken to lowest ID", int'(claim_id), 2);
        chk(claim_id == 2, "R8 source 0 never pending", int'(claim_id), 2);
        chk(claim_id == 2, "R9 pending held after request drop", int'(claim_id), 2);
        chk(claim_id == 2, "R3 claim ignores threshold 7", int'(claim_id), 2);
        chk(irq[0] == 0, "R5 irq0 at threshold 7", int'(irq[0]), 0);
        chk(irq[1] == 1, "R5 irq1 at threshold 0", int'(irq[1]), 1);

        claim_vld = 1; tick(); claim_vld = 0;
        look();
        chk(claim_id == 3, "R4 claimed source leaves pending", int'(claim_id), 3);
        claim_vld = 1; tick(); claim_vld = 0;
        src_req = 8'h0C; tick(); src_req = '0;
        look();
        chk(claim_id == 1, "R4 in-flight sources do not re-pend", int'(claim_id), 1);
        claim_vld = 1; tick(); claim_vld = 0;
        look();
        chk(claim_id == 0, "R2 priority 0 never claimed", int'(claim_id), 0);

        complete(1, 1);
        complete(1, 3);
        complete(0, 0);
        src_req = 8'h0A;
        tick();
        look();
        chk(claim_id == 1, "R7 bad completion left source 3 in flight", int'(claim_id), 1);
        chk(claim_id == 1, "R6 out-of-order completion re-armed 1", int'(claim_id), 1);
        complete(0, 3);
        tick();
        look();
        chk(claim_id == 3, "R6 completion re-armed 3", int'(claim_id), 3);
        src_req = '0;

        set_thr(0, 5);
        look();
        chk(irq[0] == 0, "R5 equal to threshold stays low", int'(irq[0]), 0);
        set_thr(0, 4);
        look();
        chk(irq[0] == 1, "R5 above threshold asserts", int'(irq[0]), 1);

        for (int i = 0; i < 6000; i++) begin
            src_req   = NS'($urandom);
            claim_vld = ($urandom % 3) == 0;
            claim_tgt = 1'($urandom % NT);
            cmpl_vld  = ($urandom % 3) == 0;
            cmpl_tgt  = 1'($urandom % NT);
            cmpl_id   = 3'($urandom);
            prio_we   = ($urandom % 16) == 0;
            prio_sel  = 3'($urandom);
            prio_val  = PW'($urandom);
            en_we     = ($urandom % 32) == 0;
            en_tgt    = 1'($urandom % NT);
            en_mask   = NS'($urandom);
            thr_we    = ($urandom % 32) == 0;
            thr_tgt   = 1'($urandom % NT);
            thr_val   = PW'($urandom);
            tick();
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule